// File: doc/BRIEF.md
# Multicart Mapper Register File

This block is the write side of a cartridge bank-switching controller on an 8-bit CPU bus. The CPU first writes a register number into a select window at $5000-$5FFF. It then writes the register contents anywhere in $8000-$FFFF. Four registers are held: a two-bit character-RAM bank, a four-bit inner program bank, a six-bit mode word and an outer program bank. The mode word holds the mirroring mode, the program bank mode and the outer bank size. The block drives the character-RAM bank address bits directly. It also drives the nametable A10 select, which it chooses from the two-bit mirroring mode and the PPU address lines. The program bank fields are exported unchanged, for the address logic that sits next to this block.

A small redirect lets the block behave like a simple single-screen board. While a one-screen mirroring mode is active, data bit 4 of any write to the two user registers becomes the low bit of the mirroring mode. In the vertical and horizontal modes that bit has no effect on mirroring.

The bus inputs are assumed to be sampled synchronously by `clk`, which runs much faster than the CPU bus clock. `por_n` is the power-on reset. A console reset is not wired to this block, so the register contents survive it.

Top module: `mcart_regfile`

## Requirements
- R1: After power-on reset the outputs are: chr_bank 0, inner_bank 0, mirror_mode 0, prg_mode 3, outer_size 0, outer_bank all ones. The register select points at the character bank register (register number 0).
- R2: A write with cpu_addr_hi equal to 4'h5 sets the register select. Data bit 7 and data bit 0 form the register number {D7,D0}: 0 is the character bank, 1 the inner bank, 2 the mode word, 3 the outer bank. All other data bits are ignored.
- R3: A write with cpu_addr_hi bit 3 set stores data into the selected register. A write in any other window, such as 4'h4 or 4'h6, leaves every output unchanged.
- R4: Register 0 stores data bits 1..0 on chr_bank.
- R5: Register 1 stores data bits 3..0 on inner_bank.
- R6: Register 2 stores data bits 1..0 on mirror_mode, bits 3..2 on prg_mode and bits 5..4 on outer_size.
- R7: Register 3 stores the low OUTER_W data bits on outer_bank. No write to registers 0, 1 or 2 changes outer_bank.
- R8: While mirror_mode is 0 or 1, a write to register 0 or 1 also sets mirror_mode bit 0 to data bit 4.
- R9: While mirror_mode is 2 or 3, a write to register 0 or 1 leaves mirror_mode unchanged.
- R10: nt_a10 follows mirror_mode: 0 for mode 0, 1 for mode 1, ppu_a10 for mode 2, and ppu_a11 for mode 3.
- R11: A write takes effect once per bus cycle, when cpu_m2 falls. It must have had cpu_rw low while cpu_m2 was high. The data and address are those present during the high phase. The result appears on the outputs one clk after the falling level is sampled. A read cycle (cpu_rw high) changes nothing.
- R12: A write to register 0 or 1 never changes prg_mode, outer_size, outer_bank or mirror_mode bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than the CPU bus clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| cpu_m2 | input | 1 | CPU bus clock phase; high while the bus is valid |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_addr_hi | input | 4 | CPU address bits 15..12 |
| cpu_data | input | 8 | CPU data bus (only read by the block) |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| chr_bank | output | CHR_W | Character-RAM bank address bits |
| nt_a10 | output | 1 | Nametable A10 select |
| inner_bank | output | INNER_W | Inner program bank |
| mirror_mode | output | 2 | Mirroring mode |
| prg_mode | output | 2 | Program bank mode |
| outer_size | output | 2 | Outer bank size code |
| outer_bank | output | OUTER_W | Outer program bank |

## Verification
The register path is exercised with value writes that have no select write before them, so they land in the power-on target. Select writes with noise in the unused data bits check that only D7 and D0 steer the value writes. Writes in neighbouring address windows and read cycles are also driven, and they must leave every output unchanged. Each bus cycle replaces the data with its inverse at the moment cpu_m2 falls, which shows whether the block keeps high-phase data or later data. The redirect is tried with bit 4 set and clear, under one-screen and vertical/horizontal modes, and through a write to the outer bank register. This shows that the redirect depends on both the mode and the target register. The PPU lines toggle every cycle, so each mirroring mode is checked against both of them.

// File: rtl/mcart_pkg.sv
// Shared types for the multicart mapper register file.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package mcart_pkg;

    // Register numbers formed from {D7, D0} of a select write
    typedef enum logic [1:0] {
        SEL_CHR   = 2'b00,
        SEL_INNER = 2'b01,
        SEL_MODE  = 2'b10,
        SEL_OUTER = 2'b11
    } regsel_e;

    // Mirroring mode codes
    localparam logic [1:0] MIR_ONE_LO = 2'd0;
    localparam logic [1:0] MIR_ONE_HI = 2'd1;
    localparam logic [1:0] MIR_VERT   = 2'd2;
    localparam logic [1:0] MIR_HORIZ  = 2'd3;

    // Mode word, packed in write-data bit order (D5..D0)
    typedef struct packed {
        logic [1:0] size;
        logic [1:0] prg;
        logic [1:0] mir;
    } mode_t;

endpackage

// File: rtl/mcart_bus_if.sv
// Bus write detector: samples the CPU bus on clk and flags one commit
// per bus cycle, on the falling level of M2 after a write-phase high.
// Assumes the bus inputs are already synchronous to clk, and that clk
// takes at least two samples in each M2 phase.
module mcart_bus_if #(
    parameter int          DATA_W   = 8,
    parameter int          AHI_W    = 4,
    parameter logic [3:0]  SEL_PAGE = 4'h5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cpu_m2,
    input  logic              cpu_rw,
    input  logic [AHI_W-1:0]  cpu_addr_hi,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              sel_wr,
    output logic              val_wr,
    output logic [DATA_W-1:0] wr_data
);
    logic              m2_q;
    logic              rw_q;
    logic [AHI_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;
    logic              commit;

    // Hold the last bus sample so high-phase data is still available at the fall
    always_ff @(posedge clk) begin
        if (!por_n) begin
            m2_q   <= 1'b0;
            rw_q   <= 1'b1;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            m2_q   <= cpu_m2;
            rw_q   <= cpu_rw;
            addr_q <= cpu_addr_hi;
            data_q <= cpu_data;
        end
    end

    // Commit on the first low sample after a high write-phase sample
    always_comb begin
        commit  = m2_q && !cpu_m2 && !rw_q;
        sel_wr  = commit && (addr_q == SEL_PAGE[AHI_W-1:0]);
        val_wr  = commit && addr_q[AHI_W-1];
        wr_data = data_q;
    end

endmodule

// File: rtl/mcart_regs.sv
// Register storage: select latch, CHR bank, inner bank, mode word and
// outer bank, including the one-screen mirroring redirect.
// Assumes sel_wr and val_wr are single-cycle pulses and never both high.
module mcart_regs
    import mcart_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CHR_W   = 2,
    parameter int INNER_W = 4,
    parameter int OUTER_W = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sel_wr,
    input  logic               val_wr,
    input  logic [DATA_W-1:0]  wr_data,
    output regsel_e            reg_sel,
    output logic [CHR_W-1:0]   chr_bank,
    output logic [INNER_W-1:0] inner_bank,
    output mode_t              mode,
    output logic [OUTER_W-1:0] outer_bank
);
    localparam int MIRROR_SRC_BIT = 4;
    localparam int MODE_W         = $bits(mode_t);

    logic user_wr;

    // A user-register write is the only source of the mirroring redirect
    always_comb user_wr = val_wr && !reg_sel[1];

    // Latch the register number from D7 and D0
    always_ff @(posedge clk) begin
        if (!por_n)      reg_sel <= SEL_CHR;
        else if (sel_wr) reg_sel <= regsel_e'({wr_data[DATA_W-1], wr_data[0]});
    end

    // CHR bank register
    always_ff @(posedge clk) begin
        if (!por_n)                            chr_bank <= '0;
        else if (val_wr && reg_sel == SEL_CHR) chr_bank <= wr_data[CHR_W-1:0];
    end

    // Inner program bank register
    always_ff @(posedge clk) begin
        if (!por_n)                              inner_bank <= '0;
        else if (val_wr && reg_sel == SEL_INNER) inner_bank <= wr_data[INNER_W-1:0];
    end

    // Mode word, with bit-4 redirect into the mirroring low bit in one-screen modes
    always_ff @(posedge clk) begin
        if (!por_n) begin
            mode.size <= 2'd0;
            mode.prg  <= 2'd3;
            mode.mir  <= MIR_ONE_LO;
        end else if (val_wr && reg_sel == SEL_MODE) begin
            mode <= mode_t'(wr_data[MODE_W-1:0]);
        end else if (user_wr && !mode.mir[1]) begin
            mode.mir[0] <= wr_data[MIRROR_SRC_BIT];
        end
    end

    // Outer program bank register, width chosen at build time
    always_ff @(posedge clk) begin
        if (!por_n)                              outer_bank <= '1;
        else if (val_wr && reg_sel == SEL_OUTER) outer_bank <= wr_data[OUTER_W-1:0];
    end

endmodule

// File: rtl/mcart_nt_sel.sv
// Nametable A10 selector: a fixed level for the one-screen modes, or one
// of the PPU address lines for the two-screen modes.
// Assumes the PPU lines are valid whenever nt_a10 is used.
module mcart_nt_sel
    import mcart_pkg::*;
(
    input  logic [1:0] mir,
    input  logic       ppu_a10,
    input  logic       ppu_a11,
    output logic       nt_a10
);
    // Choose the A10 source from the mirroring mode
    always_comb begin
        unique case (mir)
            MIR_ONE_LO: nt_a10 = 1'b0;
            MIR_ONE_HI: nt_a10 = 1'b1;
            MIR_VERT:   nt_a10 = ppu_a10;
            default:    nt_a10 = ppu_a11;
        endcase
    end

endmodule

// File: rtl/mcart_regfile.sv
// Top of the multicart mapper register file: bus write detection,
// register storage and nametable select.
// Assumes a power-on-only reset; a console reset does not reach this block.
module mcart_regfile
    import mcart_pkg::*;
#(
    parameter int CHR_W   = 2,
    parameter int INNER_W = 4,
    parameter int OUTER_W = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               cpu_m2,
    input  logic               cpu_rw,
    input  logic [3:0]         cpu_addr_hi,
    input  logic [7:0]         cpu_data,
    input  logic               ppu_a10,
    input  logic               ppu_a11,
    output logic [CHR_W-1:0]   chr_bank,
    output logic               nt_a10,
    output logic [INNER_W-1:0] inner_bank,
    output logic [1:0]         mirror_mode,
    output logic [1:0]         prg_mode,
    output logic [1:0]         outer_size,
    output logic [OUTER_W-1:0] outer_bank
);
    localparam int DATA_W = 8;
    localparam int AHI_W  = 4;

    logic              sel_wr;
    logic              val_wr;
    logic [DATA_W-1:0] wr_data;
    regsel_e           reg_sel;
    mode_t             mode;

    mcart_bus_if #(
        .DATA_W   (DATA_W),
        .AHI_W    (AHI_W),
        .SEL_PAGE (4'h5)
    ) u_bus (
        .clk         (clk),
        .por_n       (por_n),
        .cpu_m2      (cpu_m2),
        .cpu_rw      (cpu_rw),
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_data    (cpu_data),
        .sel_wr      (sel_wr),
        .val_wr      (val_wr),
        .wr_data     (wr_data)
    );

    mcart_regs #(
        .DATA_W  (DATA_W),
        .CHR_W   (CHR_W),
        .INNER_W (INNER_W),
        .OUTER_W (OUTER_W)
    ) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .sel_wr     (sel_wr),
        .val_wr     (val_wr),
        .wr_data    (wr_data),
        .reg_sel    (reg_sel),
        .chr_bank   (chr_bank),
        .inner_bank (inner_bank),
        .mode       (mode),
        .outer_bank (outer_bank)
    );

    mcart_nt_sel u_nt (
        .mir     (mode.mir),
        .ppu_a10 (ppu_a10),
        .ppu_a11 (ppu_a11),
        .nt_a10  (nt_a10)
    );

    // Export the mode word fields
    always_comb begin
        mirror_mode = mode.mir;
        prg_mode    = mode.prg;
        outer_size  = mode.size;
    end

endmodule

// File: rtl/mcart_regfile_chk.sv
// Checker for the mapper register file, bound into the top module.
// Assumes it sees the internal commit pulse, the register select and the write data.
module mcart_regfile_chk #(
    parameter int CHR_W   = 2,
    parameter int INNER_W = 4,
    parameter int OUTER_W = 8
) (
    input logic               clk,
    input logic               por_n,
    input logic               val_wr,
    input logic [1:0]         reg_sel,
    input logic [7:0]         wr_data,
    input logic [CHR_W-1:0]   chr_bank,
    input logic [INNER_W-1:0] inner_bank,
    input logic [1:0]         mirror_mode,
    input logic [1:0]         prg_mode,
    input logic [1:0]         outer_size,
    input logic [OUTER_W-1:0] outer_bank,
    input logic               nt_a10
);
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !val_wr |=> $stable({chr_bank, inner_bank, mirror_mode, prg_mode, outer_size, outer_bank})); // R3
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
        val_wr |=> !val_wr); // R11
    AST_USER_KEEPS_SUPER: assert property (@(posedge clk) disable iff (!por_n)
        (val_wr && !reg_sel[1]) |=> $stable({prg_mode, outer_size, outer_bank, mirror_mode[1]})); // R12
    AST_HV_NO_REDIRECT: assert property (@(posedge clk) disable iff (!por_n)
        (val_wr && !reg_sel[1] && mirror_mode[1]) |=> $stable(mirror_mode)); // R9
    AST_REDIRECT_BIT: assert property (@(posedge clk) disable iff (!por_n)
        (val_wr && !reg_sel[1] && !mirror_mode[1]) |=> (mirror_mode[0] == $past(wr_data[4]))); // R8
    AST_NT_ONESCREEN: assert property (@(posedge clk) disable iff (!por_n)
        !mirror_mode[1] |-> (nt_a10 == mirror_mode[0])); // R10
    AST_OUTER_ONLY_SEL: assert property (@(posedge clk) disable iff (!por_n)
        (val_wr && reg_sel != 2'b11) |=> $stable(outer_bank)); // R7

endmodule

bind mcart_regfile mcart_regfile_chk #(
    .CHR_W   (CHR_W),
    .INNER_W (INNER_W),
    .OUTER_W (OUTER_W)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .val_wr      (val_wr),
    .reg_sel     (reg_sel),
    .wr_data     (wr_data),
    .chr_bank    (chr_bank),
    .inner_bank  (inner_bank),
    .mirror_mode (mirror_mode),
    .prg_mode    (prg_mode),
    .outer_size  (outer_size),
    .outer_bank  (outer_bank),
    .nt_a10      (nt_a10)
);

// File: tb/mcart_regfile_test.sv
// Bench for mcart_regfile: behavioural model compared on every clock,
// plus directed checks after each bus cycle.
module mcart_regfile_test;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          cpu_m2 = 1'b0;
    logic          cpu_rw = 1'b1;
    logic [3:0]    cpu_addr_hi = 4'h0;
    logic [7:0]    cpu_data = 8'h00;
    logic          ppu_a10 = 1'b0;
    logic          ppu_a11 = 1'b0;
    logic [1:0]    chr_bank;
    logic          nt_a10;
    logic [3:0]    inner_bank;
    logic [1:0]    mirror_mode;
    logic [1:0]    prg_mode;
    logic [1:0]    outer_size;
    logic [OW-1:0] outer_bank;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // Model state
    int m_sel, m_chr, m_inner, m_mir, m_prg, m_size, m_outer;

    mcart_regfile #(.OUTER_W(OW)) uut (
        .clk, .por_n, .cpu_m2, .cpu_rw, .cpu_addr_hi, .cpu_data,
        .ppu_a10, .ppu_a11, .chr_bank, .nt_a10, .inner_bank,
        .mirror_mode, .prg_mode, .outer_size, .outer_bank
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_nt();
        case (m_mir)
            0: return 0;
            1: return 1;
            2: return int'(ppu_a10);
            default: return int'(ppu_a11);
        endcase
    endfunction

    task automatic model_reset();
        m_sel = 0; m_chr = 0; m_inner = 0; m_mir = 0;
        m_prg = 3; m_size = 0; m_outer = (1 << OW) - 1;
    endtask

    task automatic model_apply(input int hi, input int d);
        if (hi == 5) begin
            m_sel = (((d >> 7) & 1) << 1) | (d & 1);
        end else if (hi >= 8) begin
            case (m_sel)
                0: m_chr = d & 3;
                1: m_inner = d & 15;
                2: begin m_mir = d & 3; m_prg = (d >> 2) & 3; m_size = (d >> 4) & 3; end
                default: m_outer = d & ((1 << OW) - 1);
            endcase
            if (m_sel < 2 && m_mir < 2) m_mir = (d >> 4) & 1;
        end
    endtask

    // One bus cycle; data is inverted and rw released as M2 falls
    task automatic bus(input int hi, input int d, input bit rw);
        @(posedge clk); #1;
        cpu_addr_hi = hi[3:0]; cpu_data = d[7:0]; cpu_rw = rw; cpu_m2 = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        cpu_m2 = 1'b0; cpu_data = ~d[7:0]; cpu_rw = 1'b1;
        @(posedge clk); #1;
        if (!rw) model_apply(hi, d);
        @(posedge clk); #1;
    endtask

    task automatic power_on();
        cmp_en = 1'b0;
        @(posedge clk); #1;
        por_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        por_n = 1'b1;
        cmp_en = 1'b1;
    endtask

    // PPU address lines toggle every clock
    initial begin
        forever begin
            @(posedge clk); #1;
            {ppu_a11, ppu_a10} = 2'({ppu_a11, ppu_a10} + 2'd1);
        end
    end

    // Compare against the model on every clock, away from the active edge; watchdog
    always @(negedge clk) begin
        cyc++;
        if (cmp_en) begin
            chk({cur_req, " chr_bank"},   int'(chr_bank),    m_chr);
            chk({cur_req, " inner_bank"}, int'(inner_bank),  m_inner);
            chk({cur_req, " mirror"},     int'(mirror_mode), m_mir);
            chk({cur_req, " prg_mode"},   int'(prg_mode),    m_prg);
            chk({cur_req, " outer_size"}, int'(outer_size),  m_size);
            chk({cur_req, " outer_bank"}, int'(outer_bank),  m_outer);
            chk({cur_req, " nt_a10"},     int'(nt_a10),      model_nt());
        end
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        power_on();
        @(posedge clk); #1;
        // R1 power-on values
        chk("R1 prg_mode", int'(prg_mode), 3);
        chk("R1 outer_bank", int'(outer_bank), 255);
        chk("R1 mirror", int'(mirror_mode), 0);

        // R1 select defaults to CHR; R4, R8 redirect with bit 4 set
        cur_req = "R4";
        bus(8, 8'h13, 1'b0);
        chk("R4 chr_bank", int'(chr_bank), 3);
        chk("R8 mirror redirect", int'(mirror_mode), 1);

        // R11 read cycle changes nothing
        cur_req = "R11";
        bus(8, 8'h00, 1'b1);
        chk("R11 read chr_bank", int'(chr_bank), 3);

        // R3 other windows ignored
        cur_req = "R3";
        bus(6, 8'h00, 1'b0);
        bus(4, 8'h00, 1'b0);
        chk("R3 chr_bank", int'(chr_bank), 3);
        chk("R3 mirror", int'(mirror_mode), 1);

        // R5 inner bank, R8 bit 4 clear; R11 high-phase data used
        cur_req = "R5";
        bus(5, 8'h01, 1'b0);
        bus(8, 8'hEA, 1'b0);
        chk("R5 inner_bank", int'(inner_bank), 10);
        chk("R8 mirror cleared", int'(mirror_mode), 0);

        // R2 noisy select bits pick register 0
        cur_req = "R2";
        bus(5, 8'h7E, 1'b0);
        bus(12, 8'h02, 1'b0);
        chk("R2 chr_bank", int'(chr_bank), 2);
        chk("R2 inner kept", int'(inner_bank), 10);

        // R6 mode word fields
        cur_req = "R6";
        bus(5, 8'h80, 1'b0);
        bus(8, 8'h2E, 1'b0);
        chk("R6 size", int'(outer_size), 2);
        chk("R6 prg", int'(prg_mode), 3);
        chk("R6 mirror", int'(mirror_mode), 2);

        // R9, R12 user write in vertical mode
        cur_req = "R9";
        bus(5, 8'h00, 1'b0);
        bus(8, 8'h11, 1'b0);
        chk("R9 mirror kept", int'(mirror_mode), 2);
        chk("R12 prg kept", int'(prg_mode), 3);
        chk("R12 outer kept", int'(outer_bank), 255);

        // R7 outer bank
        cur_req = "R7";
        bus(5, 8'h81, 1'b0);
        bus(15, 8'h5A, 1'b0);
        chk("R7 outer_bank", int'(outer_bank), 8'h5A);

        // R10 horizontal and one-screen high via mode word
        cur_req = "R10";
        bus(5, 8'h80, 1'b0);
        bus(8, 8'h03, 1'b0);
        repeat (4) @(posedge clk);
        bus(8, 8'h01, 1'b0);
        repeat (4) @(posedge clk);
        bus(8, 8'h00, 1'b0);
        repeat (4) @(posedge clk);

        // R8 redirect does not come from the outer bank register
        cur_req = "R8";
        bus(5, 8'h81, 1'b0);
        bus(8, 8'h10, 1'b0);
        chk("R8 outer write no redirect", int'(mirror_mode), 0);
        bus(5, 8'h01, 1'b0);
        bus(8, 8'h15, 1'b0);
        chk("R8 inner write redirect", int'(mirror_mode), 1);

        // R1 power-on restores defaults
        cur_req = "R1";
        power_on();
        @(posedge clk); #1;
        chk("R1 again outer", int'(outer_bank), 255);
        chk("R1 again inner", int'(inner_bank), 0);
        bus(8, 8'h01, 1'b0);
        chk("R1 select default", int'(chr_bank), 1);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule